// File: doc/BRIEF.md
# Queued SPI Command Chip-Select Controller

This block is a SPI master that works through a small queue of commands. Each queue slot pairs a data word with a control byte. The control byte carries four things: a chip-select pattern, a word-length select, a delay enable and a continue flag. Software fills the slots and sets up the configuration through a single register write port. It then writes the enable bit, and the block runs every slot from the start pointer to the end pointer, inclusive. For each slot it shifts the word out on MOSI, MSB first, and collects the same number of bits from MISO.

Each chip-select pin has an owner that is chosen per pin. A pin that is not assigned to the queue always shows its port data bit. An assigned pin shows the pattern of the active command while a transfer runs. Between transfers, the continue flag decides what an assigned pin shows: either it returns to its port data bit, or it keeps the command pattern until the next transfer begins. The direction register decides which pins are driven. A pin that is not driven is high-impedance.

Top module: `qcmd_spi`

## Requirements
- R1: Register write addresses: 0-15 set the data words and 16-31 set the control bytes (bit7 continue, bit6 word-length select, bit5 delay enable, bits 3:0 chip-select pattern). The configuration registers are: 32 assignment mask, 33 port data (reset 4'b1111), 34 direction (reset 0), 35 baud divisor (reset 1), 36 bits field, 37 delay value, 38 pointers (start in bits 3:0, end in bits 7:4), 39 enable (bit0). A pin whose assignment bit is 0 shows its port data bit at all times, including during transfers.
- R2: `csOe` equals the direction register from the cycle after the write; a pin with `csOe` low is high-impedance.
- R3: When the queue has never been started, or has been disabled by writing 0 to the enable register, every `csOut` bit equals its port data bit whatever the assignment mask holds.
- R4: During a transfer, each assigned pin shows the corresponding bit of the active command's pattern.
- R5: With continue 0, assigned pins return to port data at the final SCK falling edge and stay there until the next transfer starts. With the fixed gap this lasts 18 sampled cycles.
- R6: With continue 1 and an identical pattern in the next command, the pins hold the pattern with no break across chained transfers.
- R7: With continue 1 and a different next pattern, the pins keep the old pattern until the next transfer starts and then switch straight to the new one, never showing port data.
- R8: With word-length select 0, a word is 8 bits. With select 1, a bits field of 8-15 gives that many bits and any other value gives 16. The low bits of the data word are sent MSB first. The received bits appear right-justified on `rxData`, with a one-cycle `rxValid` pulse at the final falling edge.
- R9: SCK idles low. Each half period lasts a number of clocks equal to the baud divisor, with 0 treated as 1. MOSI changes on falling edges and MISO is sampled on rising edges.
- R10: The time from the final falling SCK edge of one transfer to the first rising edge of the next is G + baud + 1 clocks. G is 17 when the delay enable is 0. When the delay enable is 1, G is 32 times the delay value, or 8192 if that value is 0.
- R11: The queue runs the slots from start to end inclusive. It then clears `busy` and sets `done`. Starting the queue clears `done`.
- R12: If the last command had continue 1, its pattern stays on the assigned pins after `done` until the enable register is written.
- R13: Writing 0 to the enable register during a transfer stops it at once: SCK goes low, `busy` clears, the pins show port data, and no further edges follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register write address |
| regWdata | input | 16 | Register write data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 4 | Chip-select pin values |
| csOe | output | 4 | Chip-select output enables |
| rxData | output | 16 | Last received word, right-justified |
| rxValid | output | 1 | One-cycle pulse when rxData updates |
| busy | output | 1 | Queue running |
| done | output | 1 | Queue reached its end slot |

## Verification
Two events can land on the same clock edge: the final SCK falling edge, where the queue hands the pins back, and a software write to the port data register. The bench counts rising SCK edges to find the last bit of a transfer. It then times a port-register write so that the write is captured on exactly the edge that ends the transfer. In the following cycle it expects SCK low, `rxValid` high and the assigned pins already showing the newly written port value.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP
  } qState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture the slot word and pattern
    logic sample;  // take one MISO bit (rising SCK)
    logic shift;   // advance MOSI (falling SCK, more bits left)
    logic finish;  // final falling SCK: publish received word
  } dpStrobe_t;

  // Control byte fields
  localparam int CTL_CONT  = 7;
  localparam int CTL_BITSE = 6;
  localparam int CTL_DT    = 5;

  // Configuration register select (low address bits in bank 2)
  localparam logic [2:0] REG_ASSIGN = 3'd0;
  localparam logic [2:0] REG_PORT   = 3'd1;
  localparam logic [2:0] REG_DIR    = 3'd2;
  localparam logic [2:0] REG_BAUD   = 3'd3;
  localparam logic [2:0] REG_BITS   = 3'd4;
  localparam logic [2:0] REG_DELAY  = 3'd5;
  localparam logic [2:0] REG_PTRS   = 3'd6;
  localparam logic [2:0] REG_EN     = 3'd7;

endpackage

// File: rtl/qcmd_regs.sv
module qcmd_regs
  import qcmd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] cmdWord,
  output logic [7:0]        cmdCtl,
  output logic [NUM_CS-1:0] csAssign,
  output logic [NUM_CS-1:0] csPort,
  output logic [NUM_CS-1:0] csDir,
  output logic [7:0]        baudDiv,
  output logic [3:0]        bitsField,
  output logic [7:0]        delayVal,
  output logic [IDX_W-1:0]  startPtr,
  output logic [IDX_W-1:0]  endPtr,
  output logic              enWr,
  output logic              enVal
);

  logic [WORD_W-1:0] dataMem [DEPTH];
  logic [7:0]        ctlMem  [DEPTH];

  logic [1:0]       bank;
  logic [IDX_W-1:0] slot;
  logic [2:0]       regSel;
  logic             dataWe, ctlWe, cfgWe;

  assign bank   = regAddr[ADDR_W-1 -: 2];
  assign slot   = regAddr[IDX_W-1:0];
  assign regSel = regAddr[2:0];
  assign dataWe = regWe && (bank == 2'd0);
  assign ctlWe  = regWe && (bank == 2'd1);
  assign cfgWe  = regWe && (bank == 2'd2);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataMem[i] <= '0;
        ctlMem[i]  <= '0;
      end else begin
        if (dataWe && slot == IDX_W'(i)) dataMem[i] <= regWdata;
        if (ctlWe && slot == IDX_W'(i))  ctlMem[i]  <= regWdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csAssign  <= '0;
      csPort    <= '1;
      csDir     <= '0;
      baudDiv   <= 8'd1;
      bitsField <= '0;
      delayVal  <= '0;
      startPtr  <= '0;
      endPtr    <= '0;
    end else if (cfgWe) begin
      unique case (regSel)
        REG_ASSIGN: csAssign  <= regWdata[NUM_CS-1:0];
        REG_PORT:   csPort    <= regWdata[NUM_CS-1:0];
        REG_DIR:    csDir     <= regWdata[NUM_CS-1:0];
        REG_BAUD:   baudDiv   <= regWdata[7:0];
        REG_BITS:   bitsField <= regWdata[3:0];
        REG_DELAY:  delayVal  <= regWdata[7:0];
        REG_PTRS: begin
          startPtr <= regWdata[IDX_W-1:0];
          endPtr   <= regWdata[2*IDX_W-1:IDX_W];
        end
        default: ;
      endcase
    end
  end

  assign enWr    = cfgWe && (regSel == REG_EN);
  assign enVal   = regWdata[0];
  assign cmdWord = dataMem[rdIdx];
  assign cmdCtl  = ctlMem[rdIdx];

endmodule

// File: rtl/qcmd_ctrl.sv
module qcmd_ctrl
  import qcmd_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int IDX_W      = 4,
  parameter int MIN_BITS   = 8,
  parameter int FIXED_GAP  = 17,
  parameter int DELAY_UNIT = 32,
  parameter int DELAY_ZERO = 8192,
  parameter int LEN_W      = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWr,
  input  logic             enVal,
  input  logic [IDX_W-1:0] startPtr,
  input  logic [IDX_W-1:0] endPtr,
  input  logic             ctlCont,
  input  logic             ctlBitse,
  input  logic             ctlDt,
  input  logic [7:0]       baudDiv,
  input  logic [7:0]       delayVal,
  input  logic [3:0]       bitsField,
  output logic [IDX_W-1:0] rdIdx,
  output dpStrobe_t        stb,
  output logic [LEN_W-1:0] lenNow,
  output logic             sck,
  output logic             queueOwn,
  output logic             busy,
  output logic             done
);

  localparam int GAP_W = $clog2(DELAY_ZERO + 1);

  qState_e          state;
  logic [IDX_W-1:0] ptr;
  logic [7:0]       halfCnt, baudEff;
  logic [LEN_W-1:0] bitCnt, lenQ;
  logic [GAP_W-1:0] gapCnt, gapNow;
  logic             sckQ, running, held, doneQ, curCont, curDt;
  logic             startNow, stopNow, halfEnd;

  assign startNow = enWr && enVal && !running;
  assign stopNow  = enWr && !enVal;
  assign halfEnd  = (state == ST_SHIFT) && (halfCnt == 8'd0);

  always_comb begin
    if (!ctlBitse)                      lenNow = LEN_W'(MIN_BITS);
    else if (bitsField >= 4'(MIN_BITS)) lenNow = LEN_W'(bitsField);
    else                                lenNow = LEN_W'(WORD_W);
    baudEff = (baudDiv == 8'd0) ? 8'd1 : baudDiv;
    if (!curDt)                 gapNow = GAP_W'(FIXED_GAP);
    else if (delayVal == 8'd0)  gapNow = GAP_W'(DELAY_ZERO);
    else                        gapNow = GAP_W'(delayVal) * GAP_W'(DELAY_UNIT);
  end

  always_comb begin
    stb.load   = (state == ST_LOAD);
    stb.sample = halfEnd && !sckQ;
    stb.shift  = halfEnd && sckQ && (bitCnt != '0);
    stb.finish = halfEnd && sckQ && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ptr     <= '0;
      halfCnt <= '0;
      bitCnt  <= '0;
      lenQ    <= '0;
      gapCnt  <= '0;
      sckQ    <= 1'b0;
      running <= 1'b0;
      held    <= 1'b0;
      doneQ   <= 1'b0;
      curCont <= 1'b0;
      curDt   <= 1'b0;
    end else begin
      if (enWr) held <= 1'b0;
      if (stopNow) begin
        running <= 1'b0;
        state   <= ST_IDLE;
        sckQ    <= 1'b0;
        curCont <= 1'b0;
      end else if (startNow) begin
        running <= 1'b1;
        doneQ   <= 1'b0;
        ptr     <= startPtr;
        curCont <= 1'b0;
        state   <= ST_LOAD;
      end else begin
        unique case (state)
          ST_LOAD: begin
            curCont <= ctlCont;
            curDt   <= ctlDt;
            lenQ    <= lenNow;
            bitCnt  <= lenNow - LEN_W'(1);
            halfCnt <= baudEff - 8'd1;
            sckQ    <= 1'b0;
            state   <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (halfCnt == 8'd0) begin
              halfCnt <= baudEff - 8'd1;
              if (!sckQ) begin
                sckQ <= 1'b1;
              end else begin
                sckQ <= 1'b0;
                if (bitCnt == '0) begin
                  gapCnt <= gapNow;
                  state  <= ST_GAP;
                end else begin
                  bitCnt <= bitCnt - LEN_W'(1);
                end
              end
            end else begin
              halfCnt <= halfCnt - 8'd1;
            end
          end
          ST_GAP: begin
            if (gapCnt <= GAP_W'(1)) begin
              if (ptr == endPtr) begin
                running <= 1'b0;
                doneQ   <= 1'b1;
                held    <= curCont;
                state   <= ST_IDLE;
              end else begin
                ptr   <= ptr + IDX_W'(1);
                state <= ST_LOAD;
              end
            end else begin
              gapCnt <= gapCnt - GAP_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign queueOwn = held || (running && ((state == ST_SHIFT) ||
                    (((state == ST_GAP) || (state == ST_LOAD)) && curCont)));
  assign rdIdx = ptr;
  assign sck   = sckQ;
  assign busy  = running;
  assign done  = doneQ;

  assert_sck_low_off_shift_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SHIFT) |-> !sckQ);

  assert_done_ends_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> !running);

  assert_bit_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (bitCnt < lenQ));

endmodule

// File: rtl/qcmd_dp.sv
module qcmd_dp
  import qcmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CS = 4,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [LEN_W-1:0]  lenNow,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [NUM_CS-1:0] cmdPat,
  input  logic              miso,
  input  logic              queueOwn,
  input  logic [NUM_CS-1:0] csAssign,
  input  logic [NUM_CS-1:0] csPort,
  input  logic [NUM_CS-1:0] csDir,
  output logic              mosi,
  output logic [NUM_CS-1:0] csOut,
  output logic [NUM_CS-1:0] csOe,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);

  logic [WORD_W-1:0] shReg, rxReg, rxQ;
  logic [NUM_CS-1:0] patQ;
  logic              rxValidQ;
  logic [LEN_W-1:0]  alignAmt;

  assign alignAmt = LEN_W'(WORD_W) - lenNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      rxReg    <= '0;
      rxQ      <= '0;
      patQ     <= '0;
      rxValidQ <= 1'b0;
    end else begin
      rxValidQ <= stb.finish;
      if (stb.load) begin
        shReg <= cmdWord << alignAmt;
        rxReg <= '0;
        patQ  <= cmdPat;
      end else begin
        if (stb.shift)  shReg <= shReg << 1;
        if (stb.sample) rxReg <= {rxReg[WORD_W-2:0], miso};
      end
      if (stb.finish) rxQ <= rxReg;
    end
  end

  // Per-pin owner select: queue pattern only on assigned pins
  for (genvar p = 0; p < NUM_CS; p++) begin : g_pin
    assign csOut[p] = (queueOwn && csAssign[p]) ? patQ[p] : csPort[p];
  end

  assign csOe    = csDir;
  assign mosi    = shReg[WORD_W-1];
  assign rxData  = rxQ;
  assign rxValid = rxValidQ;

  assert_rx_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxValidQ |=> !rxValidQ);

endmodule

// File: rtl/qcmd_spi.sv
module qcmd_spi
  import qcmd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int NUM_CS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic [$clog2(DEPTH)+1:0]    regAddr,
  input  logic [WORD_W-1:0]           regWdata,
  output logic                        sck,
  output logic                        mosi,
  input  logic                        miso,
  output logic [NUM_CS-1:0]           csOut,
  output logic [NUM_CS-1:0]           csOe,
  output logic [WORD_W-1:0]           rxData,
  output logic                        rxValid,
  output logic                        busy,
  output logic                        done
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 2;
  localparam int LEN_W  = $clog2(WORD_W + 1);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(2 * DEPTH + 2);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(2 * DEPTH + 7);

  logic [WORD_W-1:0] cmdWord;
  logic [7:0]        cmdCtl, baudDiv, delayVal;
  logic [NUM_CS-1:0] csAssign, csPort, csDir;
  logic [3:0]        bitsField;
  logic [IDX_W-1:0]  startPtr, endPtr, rdIdx;
  logic              enWr, enVal, queueOwn;
  logic [LEN_W-1:0]  lenNow;
  dpStrobe_t         stb;

  qcmd_regs #(.DEPTH(DEPTH), .WORD_W(WORD_W), .NUM_CS(NUM_CS),
              .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .rdIdx(rdIdx), .cmdWord(cmdWord), .cmdCtl(cmdCtl), .csAssign(csAssign),
    .csPort(csPort), .csDir(csDir), .baudDiv(baudDiv), .bitsField(bitsField),
    .delayVal(delayVal), .startPtr(startPtr), .endPtr(endPtr),
    .enWr(enWr), .enVal(enVal)
  );

  qcmd_ctrl #(.WORD_W(WORD_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enWr(enWr), .enVal(enVal),
    .startPtr(startPtr), .endPtr(endPtr),
    .ctlCont(cmdCtl[CTL_CONT]), .ctlBitse(cmdCtl[CTL_BITSE]), .ctlDt(cmdCtl[CTL_DT]),
    .baudDiv(baudDiv), .delayVal(delayVal), .bitsField(bitsField),
    .rdIdx(rdIdx), .stb(stb), .lenNow(lenNow), .sck(sck),
    .queueOwn(queueOwn), .busy(busy), .done(done)
  );

  qcmd_dp #(.WORD_W(WORD_W), .NUM_CS(NUM_CS), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .lenNow(lenNow), .cmdWord(cmdWord),
    .cmdPat(cmdCtl[NUM_CS-1:0]), .miso(miso), .queueOwn(queueOwn),
    .csAssign(csAssign), .csPort(csPort), .csDir(csDir),
    .mosi(mosi), .csOut(csOut), .csOe(csOe), .rxData(rxData), .rxValid(rxValid)
  );

  assert_oe_tracks_dir_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == DIR_ADDR) |=> (csOe == $past(regWdata[NUM_CS-1:0])));

  assert_start_clears_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == EN_ADDR && regWdata[0] && !busy) |=> (busy && !done));

endmodule

// File: tb/sim_qcmd_spi.sv
`timescale 1ns/1ps
module sim_qcmd_spi;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [5:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic sck, mosi, miso, rxValid, busy, done;
  logic [3:0] csOut, csOe;
  logic [15:0] rxData;

  always #2.5 clk = ~clk;

  qcmd_spi u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .sck(sck), .mosi(mosi), .miso(miso), .csOut(csOut),
    .csOe(csOe), .rxData(rxData), .rxValid(rxValid), .busy(busy), .done(done));

  int checks = 0;
  int errors = 0;

  // Slave model and monitor, sampled on the falling system clock
  logic [15:0] misoSh = '0;
  logic [15:0] curMosi = '0;
  logic prevSck = 1'b0;
  logic [3:0] csAtRise [64];
  int lowAtRise [64];
  logic [15:0] mosiWords [8];
  logic [15:0] rxWords [8];
  int riseTotal = 0, rxCnt = 0, lowRun = 0;
  int portHits = 0, missHits = 0, watchLo = 1000, watchHi = 0;
  logic [3:0] watchVal = '0, portVal = 4'hF;

  assign miso = misoSh[15];

  always @(negedge clk) begin
    if (sck && !prevSck) begin
      if (riseTotal < 64) begin
        csAtRise[riseTotal] = csOut;
        lowAtRise[riseTotal] = lowRun;
      end
      curMosi = {curMosi[14:0], mosi};
      riseTotal++;
    end
    if (!sck && prevSck) begin
      misoSh = misoSh << 1;
      lowRun = 0;
    end
    if (!sck) lowRun++;
    if (rxValid && rxCnt < 8) begin
      mosiWords[rxCnt] = curMosi;
      rxWords[rxCnt] = rxData;
      curMosi = '0;
      rxCnt++;
    end
    if (riseTotal >= watchLo && riseTotal < watchHi) begin
      if (csOut == portVal) portHits++;
      if (csOut != watchVal) missHits++;
    end
    prevSck = sck;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] val);
    tick();
    regWe = 1'b1;
    regAddr = 6'(addr);
    regWdata = val;
    tick();
    regWe = 1'b0;
  endtask

  task automatic clrMon();
    riseTotal = 0; rxCnt = 0; curMosi = '0; lowRun = 0;
    portHits = 0; missHits = 0; watchLo = 1000; watchHi = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 30000; i++) begin
      if (done) break;
      tick();
    end
  endtask

  task automatic waitRises(input int n);
    for (int i = 0; i < 30000; i++) begin
      if (riseTotal >= n) break;
      tick();
    end
  endtask

  // {data, ctl, bitsField, baud, misoWord}
  localparam logic [51:0] VEC [6] = '{
    {16'hA5C3, 8'h0E, 4'd0,  8'd2, 16'h5A3C},
    {16'h1234, 8'h4A, 4'd12, 8'd1, 16'h0FED},
    {16'hBEEF, 8'h45, 4'd0,  8'd3, 16'h1357},
    {16'h7F01, 8'h40, 4'd3,  8'd2, 16'hC001},
    {16'h00FF, 8'h49, 4'd15, 8'd0, 16'h7FFE},
    {16'h8001, 8'hC6, 4'd8,  8'd2, 16'h00A5}
  };

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // Reset state (R2, R3, R9, R11)
    chk("R3 reset pins", csOut, 4'hF);
    chk("R2 reset oe", csOe, 4'h0);
    chk("R9 reset sck", sck, 1'b0);
    chk("R11 reset busy/done", {busy, done}, 2'b00);

    wr(34, 16'h0005);
    chk("R2 dir write", csOe, 4'h5);
    wr(32, 16'h000F);
    wr(33, 16'h0006);
    chk("R3 idle assigned pins show port", csOut, 4'h6);

    // Table of single-command transfers (R1, R4, R8, R9, R12)
    wr(32, 16'h0007);
    wr(33, 16'h000F);
    wr(34, 16'h000F);
    for (int v = 0; v < 6; v++) begin
      logic [15:0] d, m, mask;
      logic [7:0] c, b;
      logic [3:0] bf, expDur, expAft;
      int n, be;
      {d, c, bf, b, m} = VEC[v];
      n = !c[6] ? 8 : (bf >= 4'd8 ? int'(bf) : 16);
      be = (b == 0) ? 1 : int'(b);
      mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
      expDur = (c[3:0] & 4'h7) | 4'h8;
      expAft = c[7] ? expDur : 4'hF;
      wr(39, 16'h0000);
      wr(0, d);
      wr(16, {8'h00, c});
      wr(36, {12'h000, bf});
      wr(35, {8'h00, b});
      wr(38, 16'h0000);
      tick();
      clrMon();
      misoSh = m << (16 - n);
      wr(39, 16'h0001);
      waitDone();
      chk($sformatf("R1 R12 pins after vector %0d", v), csOut, expAft);
      tick();
      chk($sformatf("R8 mosi word vector %0d", v), mosiWords[0], d & mask);
      chk($sformatf("R8 rx word vector %0d", v), rxWords[0], m & mask);
      chk($sformatf("R8 bit count vector %0d", v), riseTotal, n);
      chk($sformatf("R9 half period vector %0d", v), lowAtRise[1], be);
      for (int k = 0; k < n; k++)
        chk($sformatf("R4 R1 pins during vector %0d bit %0d", v, k), csAtRise[k], expDur);
    end
    wr(39, 16'h0000);
    chk("R12 enable write releases held pins", csOut, 4'hF);

    // R5 and R10 fixed gap: two commands, continue 0, same pattern
    wr(32, 16'h000F);
    wr(35, 16'h0002);
    wr(16, 16'h000A);
    wr(17, 16'h000A);
    wr(38, 16'h0010);
    tick();
    clrMon();
    watchLo = 8; watchHi = 9; portVal = 4'hF; watchVal = 4'hA;
    wr(39, 16'h0001);
    waitDone();
    tick();
    chk("R5 port cycles between transfers", portHits, 18);
    chk("R10 fixed gap", lowAtRise[8], 20);
    chk("R11 done after end slot", {busy, done}, 2'b01);

    // R6 chain with same pattern
    wr(16, 16'h008A);
    wr(17, 16'h008A);
    wr(18, 16'h000A);
    wr(38, 16'h0020);
    tick();
    clrMon();
    watchLo = 1; watchHi = 24; watchVal = 4'hA;
    wr(39, 16'h0001);
    waitDone();
    tick();
    chk("R6 pattern unbroken across chain", missHits, 0);
    chk("R6 chain length", riseTotal, 24);

    // R7 continue with changed pattern
    wr(16, 16'h008A);
    wr(17, 16'h0005);
    wr(38, 16'h0010);
    tick();
    clrMon();
    watchLo = 1; watchHi = 16; portVal = 4'hF; watchVal = 4'hA;
    wr(39, 16'h0001);
    waitDone();
    tick();
    chk("R7 never port between transfers", portHits, 0);
    chk("R7 old pattern at last bit", csAtRise[7], 4'hA);
    chk("R7 new pattern at first bit", csAtRise[8], 4'h5);

    // R10 programmable delay
    wr(16, 16'h002A);
    wr(17, 16'h000A);
    wr(37, 16'h0001);
    tick();
    clrMon();
    wr(39, 16'h0001);
    waitDone();
    tick();
    chk("R10 delay value 1", lowAtRise[8], 35);
    wr(37, 16'h0000);
    tick();
    clrMon();
    wr(39, 16'h0001);
    waitDone();
    tick();
    chk("R10 delay value 0", lowAtRise[8], 8195);

    // R11 start/end range
    wr(2, 16'h0011); wr(3, 16'h0022); wr(4, 16'h0033); wr(5, 16'h0044);
    wr(18, 16'h000C); wr(19, 16'h000C); wr(20, 16'h000C); wr(21, 16'h000C);
    wr(38, 16'h0042);
    tick();
    clrMon();
    wr(39, 16'h0001);
    chk("R11 start clears done", {busy, done}, 2'b10);
    waitDone();
    repeat (30) tick();
    chk("R11 words sent", rxCnt, 3);
    chk("R11 first word", mosiWords[0], 16'h0011);
    chk("R11 last word", mosiWords[2], 16'h0033);
    chk("R11 stopped after end", {busy, done, sck}, 3'b010);

    // R13 abort mid-transfer
    wr(16, 16'h0040);
    wr(36, 16'h0000);
    wr(35, 16'h0004);
    wr(38, 16'h0000);
    tick();
    clrMon();
    wr(39, 16'h0001);
    waitRises(3);
    wr(39, 16'h0000);
    chk("R13 abort stops", {busy, sck}, 2'b00);
    chk("R13 abort pins port", csOut, 4'hF);
    repeat (20) tick();
    chk("R13 no further edges", riseTotal, 3);

    // Concurrent: final falling edge and port register write on one edge (R5, R1)
    wr(35, 16'h0002);
    wr(16, 16'h0005);
    tick();
    clrMon();
    wr(39, 16'h0001);
    waitRises(8);
    tick();
    regWe = 1'b1; regAddr = 6'd33; regWdata = 16'h0003;
    tick();
    regWe = 1'b0;
    chk("R5 revert shows same-edge port write", csOut, 4'h3);
    chk("R8 rx pulse at final fall", {rxValid, sck}, 2'b10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule